// File: doc/BRIEF.md
# Endpoint Configuration Header Command and Status Registers

This block is the small configuration register file of one endpoint function. Software reaches it through a dword-addressed access port with a strobe, a write flag, an address, four byte enables and 32-bit write data; reads come back on the same cycle as the strobe. The block returns fixed identity words and holds a 16-bit Command register and a 16-bit Status register, which share dword 1. Command sits in the low half at byte offset 0x04, and Status sits in the high half at byte offset 0x06.

The block drives two outputs from these registers. The bus-master-enable level gates the function's DMA engine. The level interrupt output follows an internal interrupt request, gated by the interrupt-disable bit. Five sticky error flags in Status are set by single-cycle event inputs. Software clears a flag by writing 1 to it.

Top module: `cfg_hdr_regs`

## Requirements
- R1: Dword 0 reads {DEVICE_ID, VENDOR_ID}, with the vendor ID in bits 15:0. Dword 2 reads {CLASS_CODE, REVISION_ID}, with the revision in bits 7:0. Writes to these dwords change nothing.
- R2: Command occupies dword 1 bits 15:0 and resets to 0. Only bits 0, 1, 2, 6, 8 and 10 (mask 0x0547) are writable. Every other Command bit always reads 0.
- R3: Bus-master enable is Command bit 2, and `bus_master_en` equals that bit. When BM_CAPABLE is 0, writing 1 to the bit has no effect: it reads back 0 and `bus_master_en` stays low.
- R4: Status bit 3 (dword bit 19) reads the value `irq_req` had at the previous rising clock edge. The interrupt-disable bit does not change it.
- R5: `intx_out` is 1 exactly when Status bit 3 is 1 and Command bit 10 (interrupt disable) is 0.
- R6: Status bit 4 (dword bit 20) reads the CAP_LIST parameter. Writes do not change it.
- R7: Status bits 11 to 15 (dword bits 27 to 31) are sticky error flags. They are set by `err_evt[0]` to `err_evt[4]` in this order: signaled target abort, received target abort, received master abort, signaled system error, detected parity error.
  - Writing 1 to a flag clears it, and writing 0 leaves it unchanged.
  - An event in the same cycle as a clear leaves the flag set.
  - All other Status bits read 0.
- R8: Byte enables qualify every write.
  - `acc_be[0]` covers Command bits 7:0.
  - `acc_be[1]` covers Command bits 15:8.
  - `acc_be[3]` covers the Status error flags.
  - `acc_be[2]` alters nothing.
  - A write that covers only Status bytes leaves Command unchanged, and the reverse also holds.
- R9: Dwords 3 and above read 0. `acc_rdata` is 0 unless `acc_valid` is 1 and `acc_write` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| acc_valid | input | 1 | Access strobe |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_addr | input | ADDR_W | Dword address within the header |
| acc_be | input | 4 | Byte enables for the write |
| acc_wdata | input | 32 | Write data |
| acc_rdata | output | 32 | Read data, same cycle as the strobe |
| irq_req | input | 1 | Internal interrupt request level |
| err_evt | input | 5 | Single-cycle error event pulses |
| bus_master_en | output | 1 | Permits the function to issue memory and I/O requests |
| intx_out | output | 1 | Level interrupt output |

## Verification
A wrong byte-lane mask or a stuck Command bit shows on the dword 1 read on the first read after the write. It also shows at once on `bus_master_en` or `intx_out`. A wrong error-flag priority or clear polarity shows in Status bits 27 to 31 one cycle after the event or write. A wrongly timed interrupt sample shows as a one-cycle shift between `irq_req` and both Status bit 19 and `intx_out`. The bench sweeps all sixteen byte-enable patterns with several data words on two configurations, and it compares every dword read with a model built from the requirements.

// File: rtl/cfg_hdr_pkg.sv
`timescale 1ns/1ps
// Shared bit positions and dword indexes for the configuration header block.
package cfg_hdr_pkg;
    localparam int CMD_BME_BIT    = 2;
    localparam int CMD_INTDIS_BIT = 10;
    localparam int STS_IRQ_BIT    = 3;
    localparam int STS_CAPL_BIT   = 4;
    localparam int STS_ERR_LSB    = 11;
    localparam int ERR_CNT        = 5;

    // Command bits software may change when bus mastering is supported
    localparam logic [15:0] CMD_RW_MASK = 16'h0547;

    localparam int DW_IDENT  = 0;
    localparam int DW_CMDSTS = 1;
    localparam int DW_CLASS  = 2;

    typedef logic [15:0] hreg_t;
endpackage

// File: rtl/cfg_cmd_reg.sv
`timescale 1ns/1ps
// Command register: two byte lanes, each bit writable only where WMASK is set.
// Assumes wr_en is already qualified by strobe, write flag and address.
module cfg_cmd_reg
    import cfg_hdr_pkg::*;
#(
    parameter logic [15:0] WMASK = CMD_RW_MASK
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_en,
    input  logic [1:0] wr_be,
    input  hreg_t      wr_data,
    output hreg_t      cmd_q
);
    for (genvar b = 0; b < 2; b++) begin : g_lane
        localparam logic [7:0] LMASK = WMASK[b*8 +: 8];
        logic [7:0] lane_q;

        // Update the writable bits of this lane when its byte enable is set
        always_ff @(posedge clk) begin
            if (!rst_n)
                lane_q <= '0;
            else if (wr_en && wr_be[b])
                lane_q <= (lane_q & ~LMASK) | (wr_data[b*8 +: 8] & LMASK);
        end

        assign cmd_q[b*8 +: 8] = lane_q;
    end
endmodule

// File: rtl/cfg_sts_reg.sv
`timescale 1ns/1ps
// Status register: sampled interrupt request, constant capability-list flag,
// and sticky error flags (event sets, write-1 clears, set wins).
// Assumes err_evt pulses are synchronous to clk.
module cfg_sts_reg
    import cfg_hdr_pkg::*;
#(
    parameter bit CAP_LIST = 1'b1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               irq_req,
    input  logic [ERR_CNT-1:0] err_evt,
    input  logic               clr_en,
    input  logic [ERR_CNT-1:0] clr_bits,
    output hreg_t              sts_q,
    output logic               irq_q
);
    logic [ERR_CNT-1:0] err_vec;

    // Sample the interrupt request once per cycle
    always_ff @(posedge clk) begin
        if (!rst_n) irq_q <= 1'b0;
        else        irq_q <= irq_req;
    end

    for (genvar i = 0; i < ERR_CNT; i++) begin : g_err
        logic flag_q;

        // Sticky flag: event sets, write-1 clears, event has priority
        always_ff @(posedge clk) begin
            if (!rst_n)                    flag_q <= 1'b0;
            else if (err_evt[i])           flag_q <= 1'b1;
            else if (clr_en && clr_bits[i]) flag_q <= 1'b0;
        end

        assign err_vec[i] = flag_q;
    end

    // Assemble the 16-bit Status view
    always_comb begin
        sts_q                          = '0;
        sts_q[STS_IRQ_BIT]             = irq_q;
        sts_q[STS_CAPL_BIT]            = CAP_LIST;
        sts_q[STS_ERR_LSB +: ERR_CNT]  = err_vec;
    end
endmodule

// File: rtl/cfg_rd_mux.sv
`timescale 1ns/1ps
// Read data selection by dword address; unimplemented dwords and idle
// cycles return zero. Purely combinational.
module cfg_rd_mux
    import cfg_hdr_pkg::*;
#(
    parameter int          ADDR_W      = 4,
    parameter logic [15:0] VENDOR_ID   = 16'hC0DE,
    parameter logic [15:0] DEVICE_ID   = 16'h0A51,
    parameter logic [23:0] CLASS_CODE  = 24'h058000,
    parameter logic [7:0]  REVISION_ID = 8'h03
) (
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  hreg_t             cmd,
    input  hreg_t             sts,
    output logic [31:0]       rdata
);
    // Select the addressed dword
    always_comb begin
        rdata = '0;
        if (rd_en) begin
            case (addr)
                ADDR_W'(DW_IDENT):  rdata = {DEVICE_ID, VENDOR_ID};
                ADDR_W'(DW_CMDSTS): rdata = {sts, cmd};
                ADDR_W'(DW_CLASS):  rdata = {CLASS_CODE, REVISION_ID};
                default:            rdata = '0;
            endcase
        end
    end
endmodule

// File: rtl/cfg_hdr_regs.sv
`timescale 1ns/1ps
// Configuration header command/status register file for one endpoint
// function. Decodes the access port, holds Command and Status, and drives
// the bus-master-enable and level interrupt outputs.
// Assumes a single clock domain and ADDR_W >= 2.
module cfg_hdr_regs
    import cfg_hdr_pkg::*;
#(
    parameter int          ADDR_W      = 4,
    parameter logic [15:0] VENDOR_ID   = 16'hC0DE,
    parameter logic [15:0] DEVICE_ID   = 16'h0A51,
    parameter logic [23:0] CLASS_CODE  = 24'h058000,
    parameter logic [7:0]  REVISION_ID = 8'h03,
    parameter bit          BM_CAPABLE  = 1'b1,
    parameter bit          CAP_LIST    = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              acc_valid,
    input  logic              acc_write,
    input  logic [ADDR_W-1:0] acc_addr,
    input  logic [3:0]        acc_be,
    input  logic [31:0]       acc_wdata,
    output logic [31:0]       acc_rdata,
    input  logic              irq_req,
    input  logic [ERR_CNT-1:0] err_evt,
    output logic              bus_master_en,
    output logic              intx_out
);
    localparam logic [15:0] BME_DROP  = BM_CAPABLE ? 16'h0000 : (16'h1 << CMD_BME_BIT);
    localparam logic [15:0] CMD_WMASK = CMD_RW_MASK & ~BME_DROP;

    hreg_t cmd_q;
    hreg_t sts_q;
    logic  irq_q;
    logic  wr_cs;
    logic  rd_en;
    logic  unused_wr_bits;

    // Decode a write to the Command/Status dword and a read strobe
    always_comb begin
        wr_cs = acc_valid && acc_write && (acc_addr == ADDR_W'(DW_CMDSTS));
        rd_en = acc_valid && !acc_write;
    end

    // Byte lane 2 carries only read-only Status bits
    assign unused_wr_bits = ^{acc_be[2], acc_wdata[26:16]};

    cfg_cmd_reg #(.WMASK(CMD_WMASK)) u_cmd (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_cs),
        .wr_be   (acc_be[1:0]),
        .wr_data (acc_wdata[15:0]),
        .cmd_q   (cmd_q)
    );

    cfg_sts_reg #(.CAP_LIST(CAP_LIST)) u_sts (
        .clk      (clk),
        .rst_n    (rst_n),
        .irq_req  (irq_req),
        .err_evt  (err_evt),
        .clr_en   (wr_cs && acc_be[3]),
        .clr_bits (acc_wdata[16+STS_ERR_LSB +: ERR_CNT]),
        .sts_q    (sts_q),
        .irq_q    (irq_q)
    );

    cfg_rd_mux #(
        .ADDR_W      (ADDR_W),
        .VENDOR_ID   (VENDOR_ID),
        .DEVICE_ID   (DEVICE_ID),
        .CLASS_CODE  (CLASS_CODE),
        .REVISION_ID (REVISION_ID)
    ) u_rd (
        .rd_en (rd_en),
        .addr  (acc_addr),
        .cmd   (cmd_q),
        .sts   (sts_q),
        .rdata (acc_rdata)
    );

    // Drive the function-level outputs from register state
    always_comb begin
        bus_master_en = cmd_q[CMD_BME_BIT];
        intx_out      = irq_q && !cmd_q[CMD_INTDIS_BIT];
    end
endmodule

// File: rtl/cfg_hdr_chk.sv
`timescale 1ns/1ps
// Property checker for cfg_hdr_regs, attached by bind below.
module cfg_hdr_chk
    import cfg_hdr_pkg::*;
#(
    parameter int ADDR_W     = 4,
    parameter bit BM_CAPABLE = 1'b1
) (
    input logic              clk,
    input logic              rst_n,
    input logic              acc_valid,
    input logic              acc_write,
    input logic [ADDR_W-1:0] acc_addr,
    input logic [3:0]        acc_be,
    input logic              irq_req,
    input logic [ERR_CNT-1:0] err_evt,
    input logic              bus_master_en,
    input logic              intx_out,
    input logic [15:0]       cmd_q,
    input logic [15:0]       sts_q
);
    logic wr_cs;
    logic [ERR_CNT-1:0] err_q;

    // Local views for the properties
    always_comb begin
        wr_cs = acc_valid && acc_write && (acc_addr == ADDR_W'(DW_CMDSTS));
        err_q = sts_q[STS_ERR_LSB +: ERR_CNT];
    end

    AST_BME_UNSUPPORTED: assert property (@(posedge clk) disable iff (!rst_n)
        (BM_CAPABLE == 1'b0) |-> !bus_master_en); // R3
    AST_IRQ_SAMPLED: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (sts_q[STS_IRQ_BIT] == $past(irq_req))); // R4
    AST_INTX_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_q[CMD_INTDIS_BIT] |-> !intx_out); // R5
    AST_INTX_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && intx_out) |-> $past(irq_req)); // R5
    AST_ERR_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> ((err_q & $past(err_evt)) == $past(err_evt))); // R7
    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(wr_cs && acc_be[3])) |-> ((err_q & $past(err_q)) == $past(err_q))); // R7
    AST_CMD_LANES: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(wr_cs && (acc_be[1:0] != 2'b00))) |-> $stable(cmd_q)); // R8
endmodule

bind cfg_hdr_regs cfg_hdr_chk #(.ADDR_W(ADDR_W), .BM_CAPABLE(BM_CAPABLE)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .acc_valid     (acc_valid),
    .acc_write     (acc_write),
    .acc_addr      (acc_addr),
    .acc_be        (acc_be),
    .irq_req       (irq_req),
    .err_evt       (err_evt),
    .bus_master_en (bus_master_en),
    .intx_out      (intx_out),
    .cmd_q         (cmd_q),
    .sts_q         (sts_q)
);

// File: tb/test_cfg_hdr_regs.sv
`timescale 1ns/1ps
module test_cfg_hdr_regs;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        acc_valid = 1'b0;
    logic        acc_write = 1'b0;
    logic [3:0]  acc_addr = '0;
    logic [3:0]  acc_be = '0;
    logic [31:0] acc_wdata = '0;
    logic        irq_req = 1'b0;
    logic [4:0]  err_evt = '0;
    logic [31:0] rdata_a, rdata_b;
    logic        bme_a, bme_b, intx_a, intx_b;

    int checks = 0;
    int fails  = 0;

    logic [15:0] mcmd_a = '0, mcmd_b = '0;
    logic [4:0]  merr = '0;
    logic        mirq = 1'b0;

    always #5 clk = ~clk;

    cfg_hdr_regs i_cfg_hdr_regs (
        .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_write(acc_write),
        .acc_addr(acc_addr), .acc_be(acc_be), .acc_wdata(acc_wdata), .acc_rdata(rdata_a),
        .irq_req(irq_req), .err_evt(err_evt), .bus_master_en(bme_a), .intx_out(intx_a));

    cfg_hdr_regs #(
        .VENDOR_ID(16'h1234), .DEVICE_ID(16'h5678), .CLASS_CODE(24'h0C0330),
        .REVISION_ID(8'h10), .BM_CAPABLE(1'b0), .CAP_LIST(1'b0)
    ) i_cfg_hdr_regs_nobm (
        .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_write(acc_write),
        .acc_addr(acc_addr), .acc_be(acc_be), .acc_wdata(acc_wdata), .acc_rdata(rdata_b),
        .irq_req(irq_req), .err_evt(err_evt), .bus_master_en(bme_b), .intx_out(intx_b));

    // Model of the sampled interrupt request (R4)
    always @(posedge clk) begin
        if (!rst_n) mirq <= 1'b0;
        else        mirq <= irq_req;
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] exp_dw(input logic [3:0] a, input bit b);
        logic [15:0] s;
        s = '0;
        s[15:11] = merr;
        s[4] = b ? 1'b0 : 1'b1;
        s[3] = mirq;
        case (a)
            4'd0:    return b ? {16'h5678, 16'h1234} : {16'h0A51, 16'hC0DE};
            4'd1:    return {s, b ? mcmd_b : mcmd_a};
            4'd2:    return b ? {24'h0C0330, 8'h10} : {24'h058000, 8'h03};
            default: return 32'h0;
        endcase
    endfunction

    // One cycle of access (write or idle) plus error events; updates the model
    task automatic cyc(input logic wr, input logic [3:0] a, input logic [3:0] be,
                       input logic [31:0] wd, input logic [4:0] ev);
        logic [15:0] bm;
        @(negedge clk);
        acc_valid = wr; acc_write = wr; acc_addr = a; acc_be = be; acc_wdata = wd; err_evt = ev;
        if (wr && a == 4'd1) begin
            bm = {{8{be[1]}}, {8{be[0]}}};
            mcmd_a = (mcmd_a & ~(bm & 16'h0547)) | (wd[15:0] & bm & 16'h0547);
            mcmd_b = (mcmd_b & ~(bm & 16'h0543)) | (wd[15:0] & bm & 16'h0543);
            if (be[3]) merr = merr & ~wd[31:27];
        end
        merr = merr | ev;
        @(negedge clk);
        acc_valid = 1'b0; acc_write = 1'b0; err_evt = '0;
    endtask

    // Read one dword from both instances and compare with the model
    task automatic rd_chk(input string req, input logic [3:0] a);
        @(negedge clk);
        acc_valid = 1'b1; acc_write = 1'b0; acc_addr = a;
        #1;
        chk(req, rdata_a, exp_dw(a, 1'b0));
        chk(req, rdata_b, exp_dw(a, 1'b1));
        acc_valid = 1'b0;
    endtask

    task automatic out_chk(input string req);
        #1;
        chk(req, {31'b0, bme_a},  {31'b0, mcmd_a[2]});
        chk(req, {31'b0, bme_b},  {31'b0, mcmd_b[2]});
        chk(req, {31'b0, intx_a}, {31'b0, mirq & ~mcmd_a[10]});
        chk(req, {31'b0, intx_b}, {31'b0, mirq & ~mcmd_b[10]});
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=timeout expected=completion");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        logic [31:0] pats [3];
        pats[0] = 32'hFFFF_FFFF; pats[1] = 32'h0000_0000; pats[2] = 32'h5A5A_A5A5;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;

        // Reset state over every dword (R1, R2, R6, R9)
        for (int a = 0; a < 16; a++) rd_chk("R9 reset sweep R1 R2 R6", 4'(a));
        out_chk("R2 reset outputs");

        // No read strobe returns zero (R9)
        @(negedge clk); acc_valid = 1'b0; acc_addr = 4'd0; #1;
        chk("R9 idle rdata", rdata_a, 32'h0);
        @(negedge clk); acc_valid = 1'b1; acc_write = 1'b1; acc_addr = 4'd2; #1;
        chk("R9 write cycle rdata", rdata_a, 32'h0);
        acc_valid = 1'b0; acc_write = 1'b0;

        // Identity and unimplemented dwords ignore writes (R1, R9)
        cyc(1'b1, 4'd0, 4'hF, 32'hFFFF_FFFF, 5'h0);
        cyc(1'b1, 4'd2, 4'hF, 32'hFFFF_FFFF, 5'h0);
        cyc(1'b1, 4'd3, 4'hF, 32'hFFFF_FFFF, 5'h0);
        for (int a = 0; a < 4; a++) rd_chk("R1 identity after write", 4'(a));

        // Byte-enable sweep with several data words (R2, R3, R7, R8)
        for (int p = 0; p < 3; p++) begin
            for (int be = 0; be < 16; be++) begin
                cyc(1'b0, 4'd0, 4'h0, 32'h0, 5'h1F);
                cyc(1'b1, 4'd1, 4'(be), pats[p], 5'h0);
                rd_chk("R8 lane sweep R2 R7", 4'd1);
                out_chk("R3 bme after lane write");
            end
        end

        // Interrupt gating matrix (R4, R5)
        for (int dis = 0; dis < 2; dis++) begin
            for (int rq = 0; rq < 2; rq++) begin
                cyc(1'b1, 4'd1, 4'h3, (dis != 0) ? 32'h0000_0400 : 32'h0, 5'h0);
                @(negedge clk); irq_req = (rq != 0);
                @(negedge clk);
                rd_chk("R4 irq status", 4'd1);
                out_chk("R5 intx gating");
            end
        end
        irq_req = 1'b0;

        // Event in the same cycle as a clear keeps the flag (R7)
        cyc(1'b0, 4'd0, 4'h0, 32'h0, 5'h1F);
        cyc(1'b1, 4'd1, 4'h8, 32'hF800_0000, 5'b00100);
        rd_chk("R7 set wins", 4'd1);
        chk("R7 set wins value", {27'b0, rdata_a[31:27]}, 32'h4);
        // Write 0 leaves flags, write 1 clears the rest
        cyc(1'b1, 4'd1, 4'h8, 32'h0000_0000, 5'b00001);
        rd_chk("R7 write zero keeps", 4'd1);
        cyc(1'b1, 4'd1, 4'h8, 32'hF800_0000, 5'h0);
        rd_chk("R7 write one clears", 4'd1);

        // Bus-master enable set and cleared; non-capable stays low (R3)
        cyc(1'b1, 4'd1, 4'h1, 32'h0000_0004, 5'h0);
        rd_chk("R3 bme set", 4'd1);
        out_chk("R3 bme set out");
        chk("R3 nobm stays low", {31'b0, bme_b}, 32'h0);
        cyc(1'b1, 4'd1, 4'h2, 32'h0000_0000, 5'h0);
        out_chk("R8 high lane keeps bme");
        cyc(1'b1, 4'd1, 4'h1, 32'h0000_0000, 5'h0);
        out_chk("R3 bme cleared");

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule